// File: doc/BRIEF.md
# Serial Divider-Word Loader

This block takes divider settings for a frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a load strobe. It builds a 19-bit word from the data line, shifting one bit in on each rising serial clock edge. The word arrives most significant bit first. The bit that arrives last is a steering bit.

When the load strobe rises, the 18 payload bits go to one of two register groups. A high steering bit selects the reference group: a 14-bit reference divide ratio plus one prescaler-modulus select bit. A low steering bit selects the counter group: a 7-bit swallow count plus an 11-bit main count. Each group raises its own one-cycle update strobe when it takes a new value.

The three serial inputs are asynchronous. They pass through synchronizers into the single system clock domain, and all edges are detected there. Two conditions are flagged with a one-cycle pulse:

- A load that carries a divide ratio below the legal minimum. That load is discarded.
- A load-strobe edge while the serial clock is high. A rising edge under this condition is also discarded.

Top module: `synth_serial_prog`

## Requirements
- R1: After reset, every latched field is zero and the update strobes `ref_upd` and `ctr_upd`, `load_err` and `proto_err` are all low.
- R2: The bit on `ser_dat` is shifted in on each rising edge of `ser_clk`, MSB first. Only the last 19 bits shifted before a load count; any earlier bits have no effect.
- R3: Take bit 0 as the last bit shifted in. On a load with bit 0 = 1 and a ratio of at least 3: `ref_div` takes bits 14:1, `pre_sel` takes bit 15, bits 18:16 are ignored, and `ref_upd` pulses for exactly one cycle. `ref_div` and `pre_sel` change at no other time.
- R4: On a load with bit 0 = 0 and a main count of at least 3: `swal_cnt` takes bits 7:1, `main_cnt` takes bits 18:8, and `ctr_upd` pulses for exactly one cycle. These fields change at no other time.
- R5: A reference load whose bits 14:1 are below 3 changes no field, raises no update strobe, and pulses `load_err` for one cycle. A value of exactly 3 is accepted.
- R6: A counter load whose bits 18:8 are below 3 changes no field, raises no update strobe, and pulses `load_err` for one cycle. A value of exactly 3 is accepted.
- R7: An edge of `ser_le` in either direction that is seen while the synchronized serial clock is high pulses `proto_err` for one cycle. A rising edge under this condition loads nothing. At most one of `ref_upd`, `ctr_upd`, `load_err` and `proto_err` is high in any cycle.
- R8: A load into one group leaves the fields of the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_div | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| swal_cnt | output | 7 | Swallow count |
| main_cnt | output | 11 | Main count |
| ref_upd | output | 1 | One-cycle pulse on a reference group update |
| ctr_upd | output | 1 | One-cycle pulse on a counter group update |
| load_err | output | 1 | One-cycle pulse on a rejected prohibited ratio |
| proto_err | output | 1 | One-cycle pulse on a load-strobe edge while the serial clock is high |

## Verification
A rising serial clock edge and a rising load-strobe edge can reach the synchronized domain in the same system cycle. In that cycle a shift and a load would both be due. The bench provokes this by driving `ser_clk` and `ser_le` high in the same time step. It then expects exactly one `proto_err` pulse, no update strobe, and every field unchanged. The strobe's later fall, made while the clock is low, must raise no further flag.

// File: rtl/synth_serial_prog.sv
module synth_serial_prog #(
  parameter int SYNC_STAGES = 2,
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int MIN_RATIO   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_div,
  output logic              pre_sel,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              ref_upd,
  output logic              ctr_upd,
  output logic              load_err,
  output logic              proto_err
);
  localparam int WORD_W = 1 + SWAL_W + MAIN_W;

  logic [SYNC_STAGES-1:0] ck_sync, dt_sync, le_sync;
  logic ck_d, le_d;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sync <= '0;
      dt_sync <= '0;
      le_sync <= '0;
      ck_d    <= 1'b0;
      le_d    <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], ser_clk};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], ser_dat};
      le_sync <= {le_sync[SYNC_STAGES-2:0], ser_le};
      ck_d    <= ck_sync[SYNC_STAGES-1];
      le_d    <= le_sync[SYNC_STAGES-1];
    end

  wire ck_s    = ck_sync[SYNC_STAGES-1];
  wire le_s    = le_sync[SYNC_STAGES-1];
  wire ck_rise = ck_s & ~ck_d;
  wire le_edge = le_s ^ le_d;
  wire le_ok   = le_s & ~le_d & ~ck_s;

  wire               ctl    = sr[0];
  wire [REF_W-1:0]   ref_f  = sr[REF_W:1];
  wire               pre_f  = sr[REF_W+1];
  wire [SWAL_W-1:0]  swal_f = sr[SWAL_W:1];
  wire [MAIN_W-1:0]  main_f = sr[WORD_W-1:SWAL_W+1];
  wire ref_ok  = ref_f  >= REF_W'(MIN_RATIO);
  wire main_ok = main_f >= MAIN_W'(MIN_RATIO);
  wire take_ref = le_ok &  ctl & ref_ok;
  wire take_ctr = le_ok & ~ctl & main_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (ck_rise) sr <= {sr[WORD_W-2:0], dt_sync[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_div  <= '0;
      pre_sel  <= 1'b0;
      swal_cnt <= '0;
      main_cnt <= '0;
    end else begin
      if (take_ref) begin
        ref_div <= ref_f;
        pre_sel <= pre_f;
      end
      if (take_ctr) begin
        swal_cnt <= swal_f;
        main_cnt <= main_f;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_upd   <= 1'b0;
      ctr_upd   <= 1'b0;
      load_err  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      ref_upd   <= take_ref;
      ctr_upd   <= take_ctr;
      load_err  <= le_ok & (ctl ? ~ref_ok : ~main_ok);
      proto_err <= le_edge & ck_s;
    end

  a_r3_ref_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(ref_div) && $stable(pre_sel)) |-> ref_upd);
  a_r3_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  a_r4_ctr_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(swal_cnt) && $stable(main_cnt)) |-> ctr_upd);
  a_r4_ctr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_upd |=> !ctr_upd);
  a_r5_ref_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |-> ref_div >= REF_W'(MIN_RATIO));
  a_r6_main_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_upd |-> main_cnt >= MAIN_W'(MIN_RATIO));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_upd, ctr_upd, load_err, proto_err}));
endmodule

// File: tb/sim_synth_serial_prog.sv
module sim_synth_serial_prog;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdt = 1'b0, sle = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel;
  logic [6:0]  swal_cnt;
  logic [10:0] main_cnt;
  logic ref_upd, ctr_upd, load_err, proto_err;

  int n_chk = 0, n_bad = 0;
  int c_ref = 0, c_ctr = 0, c_lerr = 0, c_perr = 0;
  int e_ref = 0, e_ctr = 0, e_lerr = 0, e_perr = 0;
  int x_ref = 0, x_pre = 0, x_swal = 0, x_main = 0;

  always #10 clk = ~clk;

  synth_serial_prog u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_dat(sdt), .ser_le(sle),
    .ref_div(ref_div), .pre_sel(pre_sel), .swal_cnt(swal_cnt), .main_cnt(main_cnt),
    .ref_upd(ref_upd), .ctr_upd(ctr_upd), .load_err(load_err), .proto_err(proto_err)
  );

  always @(posedge clk)
    if (rst_n) begin
      c_ref  <= c_ref  + int'(ref_upd);
      c_ctr  <= c_ctr  + int'(ctr_upd);
      c_lerr <= c_lerr + int'(load_err);
      c_perr <= c_perr + int'(proto_err);
    end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    chk({req, " ref_div"}, int'(ref_div), x_ref);
    chk({req, " pre_sel"}, int'(pre_sel), x_pre);
    chk({req, " swal_cnt"}, int'(swal_cnt), x_swal);
    chk({req, " main_cnt"}, int'(main_cnt), x_main);
    chk({req, " ref_upd count"}, c_ref, e_ref);
    chk({req, " ctr_upd count"}, c_ctr, e_ctr);
    chk({req, " load_err count"}, c_lerr, e_lerr);
    chk({req, " proto_err count"}, c_perr, e_perr);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdt = w[i];
      cyc(3); sck = 1'b1; cyc(3); sck = 1'b0; cyc(3);
    end
  endtask

  task automatic pulse_le();
    sle = 1'b1; cyc(8); sle = 1'b0; cyc(8);
  endtask

  task automatic send_ref(input int r, input int p, input int junk, input string req);
    shift_bits({13'd0, 3'(junk), 1'(p), 14'(r), 1'b1}, 19);
    pulse_le();
    if (r >= 3) begin x_ref = r; x_pre = p; e_ref++; end
    else e_lerr++;
    check_all(req);
  endtask

  task automatic send_ctr(input int a, input int b, input string req);
    shift_bits({13'd0, 11'(b), 7'(a), 1'b0}, 19);
    pulse_le();
    if (b >= 3) begin x_swal = a; x_main = b; e_ctr++; end
    else e_lerr++;
    check_all(req);
  endtask

  task automatic t_reset();
    check_all("R1");
    chk("R1 strobes low", int'({ref_upd, ctr_upd, load_err, proto_err}), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++)
      send_ref(3 + int'($urandom % 16381), int'($urandom % 2), int'($urandom % 8), "R3 R8 random ref");
    for (int i = 0; i < 6; i++)
      send_ctr(int'($urandom % 128), 3 + int'($urandom % 2045), "R4 R8 random ctr");
  endtask

  task automatic t_bounds();
    send_ref(3, 1, 7, "R5 ref at floor");
    send_ref(2, 0, 0, "R5 ref below floor");
    send_ref(0, 1, 5, "R5 ref zero");
    send_ctr(127, 3, "R6 main at floor");
    send_ctr(5, 2, "R6 main below floor");
    send_ctr(0, 2047, "R4 main max");
    send_ref(16383, 0, 0, "R3 ref max");
  endtask

  task automatic t_long_word();
    shift_bits(32'hF, 4);
    shift_bits({13'd0, 3'd0, 1'b1, 14'd1234, 1'b1}, 19);
    pulse_le();
    x_ref = 1234; x_pre = 1; e_ref++;
    check_all("R2 leading bits ignored");
  endtask

  task automatic t_rise_high();
    shift_bits({13'd0, 3'd0, 1'b0, 14'd777, 1'b1}, 19);
    sck = 1'b1; cyc(4);
    sle = 1'b1; cyc(8);
    sle = 1'b0; cyc(8);
    sck = 1'b0; cyc(8);
    e_perr += 2;
    check_all("R7 rise and fall with clock high");
  endtask

  task automatic t_fall_high();
    shift_bits({13'd0, 11'd900, 7'd44, 1'b0}, 19);
    sle = 1'b1; cyc(8);
    sck = 1'b1; cyc(4);
    sle = 1'b0; cyc(8);
    sck = 1'b0; cyc(8);
    x_swal = 44; x_main = 900; e_ctr++; e_perr++;
    check_all("R7 fall with clock high after good load");
  endtask

  task automatic t_same_cycle();
    shift_bits({13'd0, 3'd0, 1'b1, 14'd555, 1'b1}, 18);
    sdt = 1'b1; cyc(3);
    sck = 1'b1; sle = 1'b1; cyc(8);
    sck = 1'b0; cyc(8);
    sle = 1'b0; cyc(8);
    e_perr++;
    check_all("R7 clock and load rise together");
  endtask

  initial begin
    cyc(100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_random();
    t_bounds();
    t_long_word();
    t_rise_high();
    t_fall_high();
    t_same_cycle();
    send_ctr(9, 10, "R4 after protocol errors");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule